// File: doc/BRIEF.md
# Multi-mode LCD timing generator

This block produces the raster timing for a parallel RGB LCD panel in the pixel clock domain. A horizontal and a vertical counter walk each line and each frame, and decoded windows of those counters give the horizontal sync, the vertical sync and the data-enable. The current counter values go out as the pixel column and row, so a pixel fetch unit can address its source directly.

One of five preset timings is chosen by a 3-bit resolution code. The code is sampled only at the last pixel of the last line, so a frame never mixes two timings. Two codes have no timing: selecting one of them keeps the previous counter lengths, forces data-enable low and raises an error flag until a legal code is taken at a later frame boundary. A parameter shifts every active width and height right by a fixed amount, and leaves the porches and syncs alone, so that short frames can be built for test.

Top module: `lcd_tgen`

## Requirements
- R1: While rst_ni is low, x_o and y_o are 0, de_o and err_o are 0, and both sync outputs sit at their inactive level.
- R2: x_o steps by one every clock from 0 to H_total-1 and then returns to 0; y_o steps by one only when x_o returns to 0, and returns to 0 after V_total-1. A line runs active, front porch, sync, back porch, and a frame orders its lines the same way. All outputs come from one register stage and are aligned with each other.
- R3: de_o is 1 exactly when x_o is below the active width, y_o is below the active height, and the selected code is legal.
- R4: hsync_o is at its active level exactly when x_o lies in [H_act+H_fp, H_act+H_fp+H_sw).
- R5: vsync_o is at its active level exactly when y_o lies in [V_act+V_fp, V_act+V_fp+V_sw).
- R6: Timings by code (active width x height; H front/sync/back; V front/sync/back), with the active width and height each shifted right by ACTIVE_SHIFT: 7 gives 800x480, 40/1/216, 10/1/35; 6 gives 640x480, 24/1/136, 18/1/27; 5 gives 480x272, 2/1/43, 2/1/12; 4 gives 480x640, 2/1/43, 4/1/8; 0 gives 400x240, 20/1/108, 2/1/20. Each frame carries H_act*V_act cycles with de_o high.
- R7: Code 1 runs exactly the timing of code 5.
- R8: mode_code_i is taken only on the clock where the counters stand at the last pixel of the last line; changes at any other time have no effect on the frame in progress. After reset the timing of RESET_CODE is in force.
- R9: Codes 2 and 3 are illegal: the next frame keeps the previous timing, de_o stays 0 for that whole frame and err_o is 1; a legal code taken at a later boundary clears err_o.
- R10: With SYNC_ACT_HIGH = 0 the syncs are active-low (idle 1); with 1 they are active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; everything is launched on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_code_i | input | 3 | Resolution code, taken at the frame boundary |
| hsync_o | output | 1 | Horizontal sync, polarity set by SYNC_ACT_HIGH |
| vsync_o | output | 1 | Vertical sync, polarity set by SYNC_ACT_HIGH |
| de_o | output | 1 | Data-enable, high on visible pixels |
| x_o | output | X_W | Current column (horizontal counter) |
| y_o | output | Y_W | Current row (vertical counter) |
| err_o | output | 1 | High during frames run under an illegal code |

## Verification
The bench builds the block with ACTIVE_SHIFT = 4 and RESET_CODE = 5, and the syncs active-low. With those values the largest preset frame is about 23 thousand cycles, so every code, including both illegal ones and the dual-scan alias, runs a full frame and shows a frame boundary. The full porch and sync lengths are kept, so the sync windows and wrap points are the real ones. Random codes are driven during the first part of each frame to show that only the value held at the last pixel takes effect.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
  localparam int unsigned AXIS_W = 12;
  localparam int unsigned CODE_W = 3;

  typedef logic [AXIS_W-1:0] span_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    span_t act;
    span_t fp;
    span_t sw;
    span_t bp;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } timing_t;

  function automatic axis_t mk_axis(int unsigned act, int unsigned fp,
                                    int unsigned sw, int unsigned bp,
                                    int unsigned shift);
    axis_t a;
    a.act = span_t'(act >> shift);
    a.fp  = span_t'(fp);
    a.sw  = span_t'(sw);
    a.bp  = span_t'(bp);
    return a;
  endfunction

  function automatic logic code_legal(code_t c);
    return !(c == code_t'(2) || c == code_t'(3));
  endfunction

  // dual-scan 1 shares the input timing of 5; illegal codes never reach here
  function automatic timing_t code_timing(code_t c, int unsigned shift);
    timing_t t;
    case (c)
      code_t'(6): begin
        t.h = mk_axis(640, 24, 1, 136, shift);
        t.v = mk_axis(480, 18, 1, 27, shift);
      end
      code_t'(5), code_t'(1): begin
        t.h = mk_axis(480, 2, 1, 43, shift);
        t.v = mk_axis(272, 2, 1, 12, shift);
      end
      code_t'(4): begin
        t.h = mk_axis(480, 2, 1, 43, shift);
        t.v = mk_axis(640, 4, 1, 8, shift);
      end
      code_t'(0): begin
        t.h = mk_axis(400, 20, 1, 108, shift);
        t.v = mk_axis(240, 2, 1, 20, shift);
      end
      default: begin
        t.h = mk_axis(800, 40, 1, 216, shift);
        t.v = mk_axis(480, 10, 1, 35, shift);
      end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/lcd_tgen_mode.sv
module lcd_tgen_mode
  import lcd_tgen_pkg::*;
#(
  parameter int unsigned ACTIVE_SHIFT = 0,
  parameter code_t       RESET_CODE   = code_t'(7)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_end_i,
  input  code_t   code_i,
  output timing_t timing_o,
  output logic    illegal_o
);
  localparam timing_t RST_TIM = code_timing(RESET_CODE, ACTIVE_SHIFT);
  localparam logic    RST_ILL = !code_legal(RESET_CODE);

  timing_t tim_q;
  logic    ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q <= RST_TIM;
      ill_q <= RST_ILL;
    end else if (frame_end_i) begin
      // illegal code keeps the old lengths so the raster keeps running
      if (code_legal(code_i)) tim_q <= code_timing(code_i, ACTIVE_SHIFT);
      ill_q <= !code_legal(code_i);
    end
  end

  assign timing_o  = tim_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis
  import lcd_tgen_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  axis_t            axis_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             active_o,
  output logic             sync_o
);
  localparam int unsigned WW = AXIS_W + 2;
  typedef logic [WW-1:0] wide_t;

  logic [CNT_W-1:0] cnt_q;
  wide_t            total, sync_beg, sync_end, cnt_w;

  always_comb begin
    cnt_w    = wide_t'(cnt_q);
    sync_beg = wide_t'(axis_i.act) + wide_t'(axis_i.fp);
    sync_end = sync_beg + wide_t'(axis_i.sw);
    total    = sync_end + wide_t'(axis_i.bp);
    last_o   = (cnt_w + wide_t'(1)) >= total;
    active_o = cnt_w < wide_t'(axis_i.act);
    sync_o   = (cnt_w >= sync_beg) && (cnt_w < sync_end);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lcd_tgen_out.sv
module lcd_tgen_out #(
  parameter int unsigned X_W           = 11,
  parameter int unsigned Y_W           = 10,
  parameter bit          SYNC_ACT_HIGH = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [X_W-1:0] h_cnt_i,
  input  logic [Y_W-1:0] v_cnt_i,
  input  logic           h_act_i,
  input  logic           v_act_i,
  input  logic           h_sync_i,
  input  logic           v_sync_i,
  input  logic           illegal_i,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           err_o
);
  logic hs_q, vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o   <= '0;
      y_o   <= '0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      de_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      x_o   <= h_cnt_i;
      y_o   <= v_cnt_i;
      hs_q  <= h_sync_i;
      vs_q  <= v_sync_i;
      de_o  <= h_act_i && v_act_i && !illegal_i;
      err_o <= illegal_i;
    end
  end

  generate
    if (SYNC_ACT_HIGH) begin : g_pos
      assign hsync_o = hs_q;
      assign vsync_o = vs_q;
    end else begin : g_neg
      assign hsync_o = ~hs_q;
      assign vsync_o = ~vs_q;
    end
  endgenerate
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
  import lcd_tgen_pkg::*;
#(
  parameter int unsigned X_W           = 11,
  parameter int unsigned Y_W           = 10,
  parameter int unsigned ACTIVE_SHIFT  = 0,
  parameter logic [2:0]  RESET_CODE    = 3'd7,
  parameter bit          SYNC_ACT_HIGH = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     mode_code_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o,
  output logic           err_o
);
  timing_t        tim;
  logic           illegal;
  logic [X_W-1:0] h_cnt;
  logic [Y_W-1:0] v_cnt;
  logic           h_last, v_last, h_act, v_act, h_sync, v_sync;
  logic           frame_end;

  assign frame_end = h_last && v_last;

  lcd_tgen_mode #(
    .ACTIVE_SHIFT(ACTIVE_SHIFT),
    .RESET_CODE  (code_t'(RESET_CODE))
  ) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_end_i(frame_end),
    .code_i     (code_t'(mode_code_i)),
    .timing_o   (tim),
    .illegal_o  (illegal)
  );

  lcd_tgen_axis #(.CNT_W(X_W)) u_h (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (1'b1),
    .axis_i  (tim.h),
    .cnt_o   (h_cnt),
    .last_o  (h_last),
    .active_o(h_act),
    .sync_o  (h_sync)
  );

  lcd_tgen_axis #(.CNT_W(Y_W)) u_v (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (h_last),
    .axis_i  (tim.v),
    .cnt_o   (v_cnt),
    .last_o  (v_last),
    .active_o(v_act),
    .sync_o  (v_sync)
  );

  lcd_tgen_out #(
    .X_W          (X_W),
    .Y_W          (Y_W),
    .SYNC_ACT_HIGH(SYNC_ACT_HIGH)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_cnt_i  (h_cnt),
    .v_cnt_i  (v_cnt),
    .h_act_i  (h_act),
    .v_act_i  (v_act),
    .h_sync_i (h_sync),
    .v_sync_i (v_sync),
    .illegal_i(illegal),
    .x_o      (x_o),
    .y_o      (y_o),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
  parameter int unsigned X_W           = 11,
  parameter int unsigned Y_W           = 10,
  parameter bit          SYNC_ACT_HIGH = 1'b0
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           de_o,
  input logic [X_W-1:0] x_o,
  input logic [Y_W-1:0] y_o,
  input logic           err_o
);
  localparam logic ON = SYNC_ACT_HIGH;

  assert_x_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o != '0) |=> (x_o == $past(x_o) + X_W'(1) || x_o == '0));

  assert_y_on_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(y_o) |-> (x_o == '0));

  assert_de_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !err_o);

  assert_hsync_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_o == ON) |-> !de_o);

  assert_vsync_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_o == ON) |-> !de_o);

  assert_err_at_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> (x_o == '0 && y_o == '0));
endmodule

bind lcd_tgen lcd_tgen_chk #(
  .X_W          (X_W),
  .Y_W          (Y_W),
  .SYNC_ACT_HIGH(SYNC_ACT_HIGH)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hsync_o(hsync_o),
  .vsync_o(vsync_o),
  .de_o   (de_o),
  .x_o    (x_o),
  .y_o    (y_o),
  .err_o  (err_o)
);

// File: tb/lcd_tgen_bench.sv
`timescale 1ns/1ps
module lcd_tgen_bench;
  localparam int X_W   = 11;
  localparam int Y_W   = 10;
  localparam int SHIFT = 4;
  localparam int NF    = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     code = 3'd5;
  logic           hsync, vsync, de, err;
  logic [X_W-1:0] x;
  logic [Y_W-1:0] y;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_tgen #(
    .X_W(X_W), .Y_W(Y_W), .ACTIVE_SHIFT(SHIFT),
    .RESET_CODE(3'd5), .SYNC_ACT_HIGH(1'b0)
  ) u_lcd_tgen (
    .clk_i(clk), .rst_ni(rst_n), .mode_code_i(code),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .x_o(x), .y_o(y), .err_o(err)
  );

  // field: 0 hact 1 hfp 2 hsw 3 hbp 4 vact 5 vfp 6 vsw 7 vbp
  function automatic int tv(input int c, input int f);
    int t[8];
    case (c)
      7: t = '{800, 40, 1, 216, 480, 10, 1, 35};
      6: t = '{640, 24, 1, 136, 480, 18, 1, 27};
      4: t = '{480, 2, 1, 43, 640, 4, 1, 8};
      0: t = '{400, 20, 1, 108, 240, 2, 1, 20};
      default: t = '{480, 2, 1, 43, 272, 2, 1, 12};
    endcase
    t[0] = t[0] >> SHIFT;
    t[4] = t[4] >> SHIFT;
    return t[f];
  endfunction

  function automatic int htot(input int c);
    return tv(c, 0) + tv(c, 1) + tv(c, 2) + tv(c, 3);
  endfunction
  function automatic int vtot(input int c);
    return tv(c, 4) + tv(c, 5) + tv(c, 6) + tv(c, 7);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mx = 0, my = 0, mt = 5, frames = 0, de_cnt = 0, exp_de = 0, exp_code = 5;
    bit merr = 0;
    int tgt[NF] = '{7, 6, 4, 0, 1, 2, 3, 5, 6, 5};
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    // R1 reset state, R10 idle level of active-low syncs
    chk("R1", "x", int'(x), 0);
    chk("R1", "y", int'(y), 0);
    chk("R1", "de", int'(de), 0);
    chk("R1", "err", int'(err), 0);
    chk("R10", "hsync idle", int'(hsync), 1);
    chk("R10", "vsync idle", int'(vsync), 1);
    rst_n = 1'b1;

    while (frames <= NF) begin
      int ex, ey, ede, ehs, evs, eerr, ecode;
      bit fstart;
      @(posedge clk);
      ex = mx; ey = my; ecode = mt; eerr = int'(merr);
      ede = (mx < tv(mt, 0) && my < tv(mt, 4) && !merr) ? 1 : 0;
      ehs = (mx >= tv(mt, 0) + tv(mt, 1) && mx < tv(mt, 0) + tv(mt, 1) + tv(mt, 2)) ? 0 : 1;
      evs = (my >= tv(mt, 4) + tv(mt, 5) && my < tv(mt, 4) + tv(mt, 5) + tv(mt, 6)) ? 0 : 1;
      fstart = (mx == 0 && my == 0);
      // model advance; the code is taken only at the last pixel of the frame (R8)
      if (mx == htot(mt) - 1) begin
        mx = 0;
        if (my == vtot(mt) - 1) begin
          my = 0;
          if (code == 3'd2 || code == 3'd3) merr = 1;
          else begin
            merr = 0;
            mt = (code == 3'd1) ? 5 : int'(code);
          end
        end else my++;
      end else mx++;

      @(negedge clk);
      chk("R2", "x", int'(x), ex);
      chk("R2", "y", int'(y), ey);
      chk("R3/R8", "de", int'(de), ede);
      chk("R4/R10", "hsync", int'(hsync), ehs);
      chk("R5/R10", "vsync", int'(vsync), evs);
      chk("R9", "err", int'(err), eerr);

      if (fstart) begin
        if (frames > 0)
          chk(exp_code == 1 ? "R7" : (exp_de == 0 ? "R9" : "R6"), "de pixels per frame",
              de_cnt, exp_de);
        frames++;
        de_cnt = 0;
        exp_code = ecode;
        exp_de = eerr ? 0 : tv(ecode, 0) * tv(ecode, 4);
      end
      if (de) de_cnt++;

      if (frames <= NF) begin
        if (my < tv(mt, 4) && ($urandom % 4) == 0) code = 3'($urandom % 8);
        else code = 3'(tgt[frames - 1]);
      end
    end
    finish_run();
  end
endmodule